// File: doc/BRIEF.md
# ADC Sampling Sequence Timer

This timer produces every control strobe for an eight-channel front end. That front end has a multiplexer ahead of a single converter with a serial output. It runs from one base clock that stands for 1 µs per cycle. It repeats a frame of 1000 cycles. The first half of each frame is cut into ten slots of 50 cycles. The second half is quiet.

Each slot opens with a 20-cycle pulse, and conversion is started on the first cycle of that pulse. When the pulse ends, a single-cycle strobe steps a decimal channel counter, which drives the multiplexer select. During the 30-cycle gap that follows, the converter is clocked fifteen times so that it shifts out one result: a leading one, twelve data bits with the MSB first, then two zeros. Only the first eight slots carry channels. The words from the last two slots are run through but are meant to be dropped by the receiver, and a flag marks which slots are live.

There is no reset pin. The position counters wrap whenever they reach or pass their last legal value. The channel counter is reloaded with zero at every frame start. As a result, any state the counters power up in is corrected within one frame.

Top module: `adc_seq_timer`

## Requirements
- R1: `frame_start` is high for exactly one cycle every 1000 cycles, at the first cycle of slot 0; the first cycle after power-up counts as that cycle.
- R2: `conv_start` is high for one cycle at offset 0 of each of the ten working slots and never in the idle half of the frame.
- R3: `slot_pulse` is high at offsets 0 to 19 of each working slot and low at all other times.
- R4: `mux_step` is high for one cycle at offset 20 (the first gap cycle) of each working slot and never elsewhere.
- R5: `chan_sel` equals the slot index (0..9) at offsets 0 to 20 of a working slot. One cycle after `mux_step` it has moved one step up, with 9 wrapping to 0. It reads 0 throughout the idle half and in the cycle after `frame_start`.
- R6: `sclk` is high at gap offsets 20, 22, ..., 48 of each working slot. That is exactly 15 pulses per slot, each 1 cycle high and 1 cycle low, and none in the idle half.
- R7: `live_slot` is high for all 50 cycles of slots 0 to 7 and low for slots 8 and 9 and the idle half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one cycle per microsecond |
| frame_start | output | 1 | One-cycle marker at the start of each frame |
| conv_start | output | 1 | Starts a conversion at the onset of a slot pulse |
| slot_pulse | output | 1 | 20-cycle active part of each working slot |
| mux_step | output | 1 | One-cycle advance strobe for the channel counter |
| chan_sel | output | 4 | Decimal multiplexer select, 0 to 9 |
| sclk | output | 1 | Serial shift clock, 15 pulses per gap |
| live_slot | output | 1 | Marks slots whose serial word carries channel data |

## Verification
Offset 20 of every working slot carries both the channel-advance strobe and the first serial clock edge. A wrong ordering of the two therefore shifts either the select value or the burst by one cycle. The bench steps through whole frames and compares every output against a model that depends only on the cycle count. This includes the cycle where both strobes rise and the following cycle, where the new channel value and the first low half of the clock must appear together. Spot windows start at random points, and each one counts the serial pulses and the channel steps inside a slot. This also catches a burst that starts or stops one cycle late.

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int SLOT_HI    = 20,
  parameter int SLOT_GAP   = 30,
  parameter int N_SLOTS    = 10,
  parameter int N_LIVE     = 8,
  parameter int BURST      = 15,
  parameter int IDLE_SLOTS = 10
) (
  input  logic       clk,
  output logic       frame_start,
  output logic       conv_start,
  output logic       slot_pulse,
  output logic       mux_step,
  output logic [3:0] chan_sel,
  output logic       sclk,
  output logic       live_slot
);
  localparam int SLOT_LEN    = SLOT_HI + SLOT_GAP;
  localparam int FRAME_SLOTS = N_SLOTS + IDLE_SLOTS;
  localparam int PW          = $clog2(SLOT_LEN);
  localparam int SW          = $clog2(FRAME_SLOTS);

  logic [PW-1:0] ph_q   = '0;
  logic [SW-1:0] slot_q = '0;
  logic [3:0]    chan_q = '0;

  logic          ph_end, active, in_gap;
  logic [PW-1:0] gap_off;

  assign ph_end  = ph_q >= PW'(SLOT_LEN - 1);
  assign active  = slot_q < SW'(N_SLOTS);
  assign in_gap  = ph_q >= PW'(SLOT_HI);
  assign gap_off = ph_q - PW'(SLOT_HI);

  always_ff @(posedge clk) begin
    ph_q <= ph_end ? '0 : ph_q + 1'b1;
    if (ph_end)
      slot_q <= (slot_q >= SW'(FRAME_SLOTS - 1)) ? '0 : slot_q + 1'b1;
  end

  assign frame_start = (slot_q == '0) && (ph_q == '0);
  assign conv_start  = active && (ph_q == '0);
  assign slot_pulse  = active && !in_gap;
  assign mux_step    = active && (ph_q == PW'(SLOT_HI));
  assign sclk        = active && in_gap && (gap_off < PW'(2 * BURST)) && !gap_off[0];
  assign live_slot   = slot_q < SW'(N_LIVE);

  always_ff @(posedge clk) begin
    if (frame_start)
      chan_q <= '0;
    else if (mux_step)
      chan_q <= (chan_q >= 4'(N_SLOTS - 1)) ? '0 : chan_q + 1'b1;
  end

  assign chan_sel = chan_q;

  // R5
  chan_step_chk: assert property (@(posedge clk)
    mux_step |=> chan_sel == (($past(chan_sel) == 4'(N_SLOTS - 1)) ? 4'd0 : $past(chan_sel) + 4'd1));

  // R5
  chan_sync_chk: assert property (@(posedge clk) frame_start |=> chan_sel == 4'd0);

  // R6
  sclk_half_chk: assert property (@(posedge clk) sclk |=> !sclk);

  // R3
  pulse_open_chk: assert property (@(posedge clk) conv_start |=> slot_pulse);

  // R4
  pulse_close_chk: assert property (@(posedge clk) $fell(slot_pulse) |-> mux_step && sclk);

  // R2
  conv_range_chk: assert property (@(posedge clk) conv_start |-> chan_sel < 4'(N_SLOTS));
endmodule

// File: tb/test_adc_seq_timer.sv
module test_adc_seq_timer;
  logic       clk = 1'b0;
  logic       frame_start, conv_start, slot_pulse, mux_step, sclk, live_slot;
  logic [3:0] chan_sel;
  int         n = 0;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) n <= n + 1;

  adc_seq_timer i_adc_seq_timer (
    .clk(clk), .frame_start(frame_start), .conv_start(conv_start),
    .slot_pulse(slot_pulse), .mux_step(mux_step), .chan_sel(chan_sel),
    .sclk(sclk), .live_slot(live_slot)
  );

  function automatic int ph_of(int c);   return c % 50; endfunction
  function automatic int sl_of(int c);   return (c / 50) % 20; endfunction
  function automatic bit act_of(int c);  return sl_of(c) < 10; endfunction
  function automatic bit e_frame(int c); return sl_of(c) == 0 && ph_of(c) == 0; endfunction
  function automatic bit e_conv(int c);  return act_of(c) && ph_of(c) == 0; endfunction
  function automatic bit e_pulse(int c); return act_of(c) && ph_of(c) < 20; endfunction
  function automatic bit e_mux(int c);   return act_of(c) && ph_of(c) == 20; endfunction
  function automatic bit e_sclk(int c);
    return act_of(c) && ph_of(c) >= 20 && ((ph_of(c) - 20) % 2 == 0);
  endfunction
  function automatic bit e_live(int c);  return sl_of(c) < 8; endfunction
  function automatic int e_chan(int c);
    if (!act_of(c)) return 0;
    return (ph_of(c) <= 20) ? sl_of(c) : (sl_of(c) + 1) % 10;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1", int'(frame_start), int'(e_frame(n)));
    chk("R2", int'(conv_start),  int'(e_conv(n)));
    chk("R3", int'(slot_pulse),  int'(e_pulse(n)));
    chk("R4", int'(mux_step),    int'(e_mux(n)));
    chk("R5", int'(chan_sel),    e_chan(n));
    chk("R6", int'(sclk),        int'(e_sclk(n)));
    chk("R7", int'(live_slot),   int'(e_live(n)));
  endtask

  initial begin
    int seed;
    int rises, steps, lives;
    bit prev;
    seed = $urandom(32'h5eed_1234);
    #5;
    chk("R1", int'(frame_start), 1);
    chk("R5", int'(chan_sel), 0);
    for (int k = 0; k < 2100; k++) begin
      @(negedge clk);
      check_all();
    end
    for (int w = 0; w < 6; w++) begin
      int skip;
      skip = $urandom_range(499, 0);
      for (int k = 0; k < skip; k++) @(negedge clk);
      while (!(act_of(n) && ph_of(n) == 0)) @(negedge clk);
      rises = 0; steps = 0; lives = 0; prev = 1'b0;
      for (int k = 0; k < 50; k++) begin
        if (sclk && !prev) rises++;
        prev = sclk;
        if (mux_step) steps++;
        if (live_slot) lives++;
        @(negedge clk);
      end
      chk("R6", rises, 15);
      chk("R4", steps, 1);
      chk("R7", lives, e_live(n - 1) ? 50 : 0);
      check_all();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule